// File: doc/BRIEF.md
# Tuner Synthesiser Serial Control Slave

This block is the serial control front end of a frequency synthesiser. It listens on a two-wire I2C bus. It answers one of four 7-bit slave addresses, and a 2-bit select input picks which one. In write transactions it takes data bytes two at a time. The leading bit of the first byte in each pair marks the pair as either a divide-ratio pair or a control pair. When a pair has been fully received and acknowledged, the block loads a 17-bit divide ratio register or a 13-bit control register. Any number of pairs may follow a single address byte.

In read transactions the block sends a status byte taken from an input port. It keeps sending fresh status bytes for as long as the master acknowledges each one. When the master leaves the acknowledge bit high, the block behaves as if a STOP had arrived and lets go of the data line. Both bus lines pass through a synchroniser and a persistence filter clocked by the system clock. Short spikes therefore never reach the protocol logic.

Top module: `tuner_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {BASE_ADDR[6:2], addr_sel_i}, with BASE_ADDR = 7'h60. For any other address the data line is left released and the bytes that follow are ignored.
- R2: Bit 0 of the address byte sets the direction: 0 selects write and 1 selects read.
- R3: In write mode the block pulls SDA low in the acknowledge slot after every data byte it receives.
- R4: A pair whose first byte has bit 7 = 0 is a ratio pair. First byte bits 6..0 go to ratio_o[14:8] and the second byte goes to ratio_o[7:0]. ratio_o[16:15] and ctrl_o do not change.
- R5: A pair whose first byte has bit 7 = 1 is a control pair. First byte bits 6..5 go to ratio_o[16:15], bits 4..0 go to ctrl_o[12:8], and the second byte goes to ctrl_o[7:0]. ratio_o[14:0] does not change.
- R6: Outputs change only when the acknowledge clock of a pair's second byte ends. A first byte on its own changes nothing.
- R7: Several pairs may follow one address byte. Each pair is classified again by its own leading bit.
- R8: A STOP that arrives part way through a byte leaves ratio_o and ctrl_o unchanged.
- R9: In read mode the block sends the status byte MSB first. It samples status_i on the SCL falling edge that ends the preceding acknowledge, and it sends another byte each time the master acknowledges.
- R10: If the master does not acknowledge a status byte, the block releases SDA and ignores further clocks until the next START.
- R11: A START or repeated START resets pair tracking, so the first data byte after the next address byte is always treated as the first byte of a pair. A STOP releases SDA.
- R12: After reset ratio_o and ctrl_o are zero and SDA is released.
- R13: A level change on SCL or SDA that lasts fewer than FILT_LEN (default 4) system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| addr_sel_i | input | 2 | Selects one of four slave addresses |
| status_i | input | 8 | Byte returned in read transactions |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| ratio_o | output | 17 | Divide ratio register |
| ctrl_o | output | 13 | Control register |

## Verification
Two events can land on the same SCL falling edge. One is the end of the master acknowledge in read mode. The other is the loading of the next status byte from status_i. The bench changes status_i while that acknowledge clock is in progress and checks that each returned byte carries the value present at the falling edge, not the value from the byte before. In write mode, releasing the acknowledge and committing a pair also happen on one edge. Randomized streams of mixed ratio and control pairs check that the registers take their new values only at that edge and never from a lone first byte.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int RATIO_W = 17;
  localparam int CTRL_W  = 13;
  localparam int LOW_W   = 15;            // ratio bits carried by the ratio pair
  localparam int HI_W    = RATIO_W - LOW_W;

  typedef enum logic [2:0] {
    BS_IDLE, BS_ADDR, BS_ADDR_ACK, BS_WR, BS_WR_ACK, BS_RD, BS_RD_ACK
  } bus_st_t;

  typedef enum logic [1:0] {
    PS_FIRST, PS_RATIO_2ND, PS_CTRL_2ND
  } pair_st_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
  parameter int N_LINES  = 2,
  parameter int FILT_LEN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] raw_i,
  output logic [N_LINES-1:0] clean_o
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(FILT_LEN - 1);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          out_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= 2'b11;
        cnt_q  <= '0;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw_i[g]};
        if (sync_q[1] == out_q) begin
          cnt_q <= '0;
        end else if (cnt_q == LIMIT) begin
          out_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
    assign clean_o[g] = out_q;
  end
endmodule

// File: rtl/i2c_bus_engine.sv
module i2c_bus_engine
  import tuner_i2c_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'h60
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [1:0] addr_sel,
  input  logic [7:0] status_i,
  output logic       sda_oe_o,
  output logic       byte_stb_o,
  output logic [7:0] byte_o,
  output logic       frame_rst_o
);
  logic       scl_p, sda_p;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] my_addr;
  bus_st_t    st_q;
  logic [7:0] sh_q;
  logic [3:0] cnt_q;
  logic       rw_q, mack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise    = scl_f & ~scl_p;
  assign scl_fall    = ~scl_f & scl_p;
  assign start_det   = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det    = scl_f & scl_p & ~sda_p & sda_f;
  assign frame_rst_o = start_det | stop_det;
  assign my_addr     = {BASE_ADDR[6:2], addr_sel};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= BS_IDLE;
      sh_q       <= '0;
      cnt_q      <= '0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_o   <= 1'b0;
      byte_stb_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_stb_o <= 1'b0;
      if (start_det) begin
        st_q     <= BS_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        st_q     <= BS_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          BS_ADDR, BS_WR: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              if (st_q == BS_WR) begin
                st_q     <= BS_WR_ACK;
                sda_oe_o <= 1'b1;
              end else if (sh_q[7:1] == my_addr) begin
                st_q     <= BS_ADDR_ACK;
                rw_q     <= sh_q[0];
                sda_oe_o <= 1'b1;
              end else begin
                st_q <= BS_IDLE;
              end
            end
          end
          BS_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                st_q     <= BS_RD;
                sh_q     <= status_i;
                sda_oe_o <= ~status_i[7];
              end else begin
                st_q     <= BS_WR;
                sda_oe_o <= 1'b0;
              end
            end
          end
          BS_WR_ACK: begin
            if (scl_fall) begin
              sda_oe_o   <= 1'b0;
              byte_stb_o <= 1'b1;
              byte_o     <= sh_q;
              cnt_q      <= '0;
              st_q       <= BS_WR;
            end
          end
          BS_RD: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                st_q     <= BS_RD_ACK;
              end else begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_o <= ~sh_q[6];
              end
            end
          end
          BS_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_f;
            end else if (scl_fall) begin
              if (mack_q) begin
                sh_q     <= status_i;
                sda_oe_o <= ~status_i[7];
                cnt_q    <= '0;
                st_q     <= BS_RD;
              end else begin
                st_q <= BS_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tuner_pair_decoder.sv
module tuner_pair_decoder
  import tuner_i2c_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               byte_stb,
  input  logic [7:0]         byte_i,
  input  logic               frame_rst,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [CTRL_W-1:0]  ctrl_o
);
  pair_st_t   ps_q;
  logic [6:0] first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q    <= PS_FIRST;
      first_q <= '0;
      ratio_o <= '0;
      ctrl_o  <= '0;
    end else if (frame_rst) begin
      ps_q <= PS_FIRST;
    end else if (byte_stb) begin
      unique case (ps_q)
        PS_FIRST: begin
          first_q <= byte_i[6:0];
          ps_q    <= byte_i[7] ? PS_CTRL_2ND : PS_RATIO_2ND;
        end
        PS_RATIO_2ND: begin
          ratio_o[LOW_W-1:0] <= {first_q, byte_i};
          ps_q               <= PS_FIRST;
        end
        PS_CTRL_2ND: begin
          ratio_o[RATIO_W-1:LOW_W] <= first_q[6 -: HI_W];
          ctrl_o                   <= {first_q[6-HI_W:0], byte_i};
          ps_q                     <= PS_FIRST;
        end
        default: ps_q <= PS_FIRST;
      endcase
    end
  end
endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
  import tuner_i2c_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'h60,
  parameter int         FILT_LEN  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         addr_sel_i,
  input  logic [7:0]         status_i,
  output logic               sda_oe_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [CTRL_W-1:0]  ctrl_o
);
  logic [1:0] clean;
  logic       scl_f, sda_f;
  logic       byte_stb, frame_rst;
  logic [7:0] byte_val;

  i2c_glitch_filter #(.N_LINES(2), .FILT_LEN(FILT_LEN)) filt_i (
    .clk(clk), .rst(rst), .raw_i({scl_i, sda_i}), .clean_o(clean)
  );
  assign scl_f = clean[1];
  assign sda_f = clean[0];

  i2c_bus_engine #(.BASE_ADDR(BASE_ADDR)) eng_i (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .addr_sel(addr_sel_i), .status_i(status_i), .sda_oe_o(sda_oe_o),
    .byte_stb_o(byte_stb), .byte_o(byte_val), .frame_rst_o(frame_rst)
  );

  tuner_pair_decoder dec_i (
    .clk(clk), .rst(rst), .byte_stb(byte_stb), .byte_i(byte_val),
    .frame_rst(frame_rst), .ratio_o(ratio_o), .ctrl_o(ctrl_o)
  );
endmodule

// File: rtl/tuner_i2c_slave_chk.sv
module tuner_i2c_slave_chk
  import tuner_i2c_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               sda_oe,
  input logic               scl_f,
  input logic               frame_rst,
  input logic               byte_stb,
  input logic [RATIO_W-1:0] ratio,
  input logic [CTRL_W-1:0]  ctrl
);
  // R6
  ratio_only_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio != $past(ratio)) |-> $past(byte_stb));

  // R6
  ctrl_only_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl != $past(ctrl)) |-> $past(byte_stb));

  // R3
  ack_before_commit_chk: assert property (@(posedge clk) disable iff (rst)
    byte_stb |-> $past(sda_oe));

  // R11
  release_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
    frame_rst |=> !sda_oe);

  // R9
  drive_moves_when_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> (!$past(scl_f) || $past(frame_rst)));
endmodule

bind tuner_i2c_slave tuner_i2c_slave_chk chk_i (
  .clk(clk), .rst(rst), .sda_oe(sda_oe_o), .scl_f(scl_f),
  .frame_rst(frame_rst), .byte_stb(byte_stb), .ratio(ratio_o), .ctrl(ctrl_o)
);

// File: tb/tuner_i2c_slave_tb.sv
module tuner_i2c_slave_tb_top;
  localparam int Q = 12;
  localparam logic [6:0] BASE = 7'h60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_line;
  logic [1:0]  addr_sel = 2'd0;
  logic [7:0]  status = 8'h00;
  logic        sda_oe;
  logic [16:0] ratio;
  logic [12:0] ctrl;
  logic [16:0] exp_ratio = '0;
  logic [12:0] exp_ctrl = '0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  tuner_i2c_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .status_i(status), .sda_oe_o(sda_oe),
    .ratio_o(ratio), .ctrl_o(ctrl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] abyte(input logic [1:0] sel, input logic rw);
    return {BASE[6:2], sel, rw};
  endfunction

  task automatic model_pair(input logic [7:0] a, input logic [7:0] b);
    if (!a[7]) exp_ratio[14:0] = {a[6:0], b};
    else begin
      exp_ratio[16:15] = a[6:5];
      exp_ctrl = {a[4:0], b};
    end
  endtask

  task automatic put_bit(input logic b, input logic glitch);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    if (glitch) begin sda_m = ~b; tick(2); sda_m = b; tick(Q - 2); end
    else tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic v);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    v = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_start();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_rstart();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input int gbit, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) put_bit(b[i], i == gbit);
    get_bit(v);
    acked = ~v;
  endtask

  task automatic rd_byte(output logic [7:0] d);
    logic v;
    for (int i = 7; i >= 0; i--) begin get_bit(v); d[i] = v; end
  endtask

  task automatic chk_regs(input string req);
    check({req, " ratio"}, 32'(ratio), 32'(exp_ratio));
    check({req, " ctrl"}, 32'(ctrl), 32'(exp_ctrl));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] d, a, b;
    void'($urandom(32'h1D5E_EED1));
    tick(6); rst = 1'b0; tick(4);
    // R12 reset state
    check("R12 ratio", 32'(ratio), 0);
    check("R12 ctrl", 32'(ctrl), 0);
    check("R12 sda", 32'(sda_oe), 0);

    // R4 ratio pair, R2 write direction, R3 data ack
    do_start();
    wr_byte(abyte(2'd0, 1'b0), -1, ak); check("R2 addr ack", 32'(ak), 1);
    wr_byte(8'h5A, -1, ak); check("R3 ack A", 32'(ak), 1);
    // R6 lone first byte does nothing yet
    chk_regs("R6");
    wr_byte(8'hC3, -1, ak); check("R3 ack B", 32'(ak), 1);
    model_pair(8'h5A, 8'hC3); tick(2); chk_regs("R4");
    // R5 + R7 control pair following in the same transaction
    wr_byte(8'hB6, -1, ak); wr_byte(8'h9E, -1, ak); model_pair(8'hB6, 8'h9E);
    tick(2); chk_regs("R5 R7");
    // R7 a further ratio pair
    wr_byte(8'h01, -1, ak); wr_byte(8'h02, -1, ak); model_pair(8'h01, 8'h02);
    tick(2); chk_regs("R7");
    do_stop();
    check("R11 stop release", 32'(sda_oe), 0);

    // R1 wrong address: no ack, data ignored
    addr_sel = 2'd1;
    do_start();
    wr_byte(abyte(2'd2, 1'b0), -1, ak); check("R1 no ack", 32'(ak), 0);
    wr_byte(8'h11, -1, ak); wr_byte(8'h22, -1, ak); check("R1 data nack", 32'(ak), 0);
    do_stop(); chk_regs("R1 ignored");

    // R8 stop in the middle of the second byte
    do_start();
    wr_byte(abyte(2'd1, 1'b0), -1, ak); check("R1 sel1 ack", 32'(ak), 1);
    wr_byte(8'h7F, -1, ak);
    for (int i = 0; i < 4; i++) put_bit(1'b1, 1'b0);
    do_stop(); chk_regs("R8");

    // R11 repeated start resets pair tracking
    do_start();
    wr_byte(abyte(2'd1, 1'b0), -1, ak);
    wr_byte(8'h05, -1, ak);
    do_rstart();
    wr_byte(abyte(2'd1, 1'b0), -1, ak);
    wr_byte(8'hE3, -1, ak); wr_byte(8'h44, -1, ak); model_pair(8'hE3, 8'h44);
    do_stop(); chk_regs("R11");

    // R13 short SDA spike while SCL high must not be a START/STOP
    do_start();
    wr_byte(abyte(2'd1, 1'b0), -1, ak);
    wr_byte(8'h33, 3, ak); wr_byte(8'h66, 5, ak); model_pair(8'h33, 8'h66);
    do_stop(); chk_regs("R13");

    // R9 read with repeated status, R10 nack ends driving
    addr_sel = 2'd2; status = 8'hA5;
    do_start();
    wr_byte(abyte(2'd2, 1'b1), -1, ak); check("R2 read ack", 32'(ak), 1);
    rd_byte(d); check("R9 byte0", 32'(d), 32'h A5);
    status = 8'h3C; put_bit(1'b0, 1'b0);
    rd_byte(d); check("R9 byte1", 32'(d), 32'h3C);
    status = 8'h81; put_bit(1'b0, 1'b0);
    rd_byte(d); check("R9 byte2", 32'(d), 32'h81);
    put_bit(1'b1, 1'b0);
    check("R10 released", 32'(sda_oe), 0);
    rd_byte(d); check("R10 idle bus", 32'(d), 32'hFF);
    do_stop();

    // R7 R4 R5 random pair streams, random address select
    for (int t = 0; t < 12; t++) begin
      logic [1:0] s;
      int np;
      s = 2'($urandom_range(0, 3));
      addr_sel = s;
      np = $urandom_range(1, 3);
      do_start();
      wr_byte(abyte(s, 1'b0), -1, ak); check("R1 rand ack", 32'(ak), 1);
      for (int p = 0; p < np; p++) begin
        a = 8'($urandom); b = 8'($urandom);
        wr_byte(a, -1, ak); wr_byte(b, -1, ak); model_pair(a, b);
      end
      do_stop(); chk_regs("R7 rand");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule